// File: doc/BRIEF.md
# Table-Driven Stepper Motor Sequencer

This block moves several stepping motors through a list of signed position increments held in a memory. Each motor owns a region of `DEPTH` consecutive words. Motor `m` begins reading at word `m*DEPTH`. All motors read their words through a single synchronous read port. A round-robin arbiter decides which motor uses that port in each cycle. Once a motor has an increment, it issues one step command and then waits. It issues the next step only after the motor's step-complete signal comes back. When the step count of an increment runs out, the motor fetches its next word.

Each word is a two's-complement number of `ENTRY_W` bits. The sign sets the direction output: 1 for positive, 0 for negative. The magnitude sets the number of steps. A zero word ends that motor's table and raises its done flag. Reaching the last word of the region has the same effect. A programmable limit bounds the wait for each completion signal. If the limit runs out, the motor stops and raises its fault flag.

Each motor runs its own state machine with these states:
- IDLE: waiting for start.
- FETCH: requesting the read port; moves to FILL when granted.
- FILL: the read data is present; a zero word returns to IDLE with done set, any other word goes to STEP.
- STEP: the step pulse is high for this one cycle; moves to WAIT_ACK.
- WAIT_ACK: an acknowledge goes to NEXT; an expired limit goes to IDLE with fault set; otherwise it stays.
- NEXT: steps still remaining go back to STEP; if the increment is finished, the motor moves to FETCH for the next word, or to IDLE with done set after the last word of the region.

Top module: `stepper_table_seq`

## Requirements
- R1: After reset, every step pulse, done flag, fault flag and the memory read strobe are low.
- R2: A start pulse makes each idle motor clear its flags and read its table from word `m*DEPTH` onward, one word after another.
- R3: A positive word `k` produces `k` step pulses with direction 1. A negative word `-k` produces `k` step pulses with direction 0.
- R4: Each step pulse lasts exactly one cycle. A motor issues no new pulse until the acknowledge for its previous pulse has arrived.
- R5: An acknowledge that arrives while a motor is not waiting for one has no effect.
- R6: A zero word sets the motor's done flag. No word after it is read.
- R7: After finishing the last word of its region (`DEPTH` words without a zero), a motor sets done.
- R8: The limit counts the cycles spent in WAIT_ACK, starting at 0. With a non-zero limit `L`, an acknowledge in cycle `L-1` or earlier is accepted. Without one, the fault flag is set, the motor stops and done stays low. Other motors continue unaffected.
- R9: A limit of zero disables the timeout.
- R10: The arbiter grants at most one read per cycle, and only to a requesting motor. The grant rotates: when all motors request at once after a start, the reads go to motors 0, 1, ... in order.
- R11: A start pulse while a motor is busy has no effect on that motor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts all idle motors |
| tmo_limit | input | TMO_W | Acknowledge wait limit in cycles; 0 disables the timeout |
| step_ack | input | N_MOTORS | Step-complete signal, one per motor |
| mem_rdata | input | ENTRY_W | Read data, valid the cycle after `mem_rd` |
| mem_rd | output | 1 | Read strobe |
| mem_addr | output | ADDR_W | Read address |
| step_pulse | output | N_MOTORS | One-cycle step command per motor |
| step_dir | output | N_MOTORS | Direction per motor: 1 for positive |
| done | output | N_MOTORS | Table finished |
| fault | output | N_MOTORS | Acknowledge timeout occurred |

## Verification
The assertions assume a memory that returns the addressed word exactly one cycle after the read strobe. They also assume that `tmo_limit` holds steady while motors are running. The bench models the memory with that fixed one-cycle latency, and it changes the limit only between runs. Its motor model raises the acknowledge for a single cycle, a set number of cycles after each pulse. Acknowledges outside WAIT_ACK are driven only on purpose, while the motors are idle, to test that they are ignored.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;
    typedef enum logic [2:0] {
        M_IDLE,
        M_FETCH,
        M_FILL,
        M_STEP,
        M_WAIT_ACK,
        M_NEXT
    } mstate_e;
endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
    parameter int N = 2,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] win
);
    logic [IW-1:0] last;

    always_comb begin
        int  c;
        logic found;
        grant = '0;
        win   = '0;
        found = 1'b0;
        for (int k = 1; k <= N; k++) begin
            c = (int'(last) + k) % N;
            if (!found && req[c]) begin
                grant[c] = 1'b1;
                win      = IW'(c);
                found    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      last <= IW'(N - 1);
        else if (|grant) last <= win;
    end

    assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_grant_requested_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);
endmodule

// File: rtl/motor_seq.sv
module motor_seq
    import stepseq_pkg::*;
#(
    parameter int ENTRY_W = 16,
    parameter int DEPTH   = 8,
    parameter int TMO_W   = 12,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               grant,
    input  logic [ENTRY_W-1:0] rdata,
    input  logic               ack,
    input  logic [TMO_W-1:0]   limit,
    output logic               req,
    output logic [IDX_W-1:0]   idx,
    output logic               step,
    output logic               dir,
    output logic               done,
    output logic               err
);
    mstate_e state, nxt;
    logic [ENTRY_W-1:0] remain;
    logic [TMO_W-1:0]   timer;
    logic [ENTRY_W-1:0] mag;
    logic               tmo;
    logic               last_word;
    logic               zero_word;

    assign mag       = rdata[ENTRY_W-1] ? (~rdata + 1'b1) : rdata;
    assign zero_word = (rdata == '0);
    assign tmo       = (limit != '0) && (timer == limit - 1'b1);
    assign last_word = (idx == IDX_W'(DEPTH - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= M_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            M_IDLE:     if (start) nxt = M_FETCH;
            M_FETCH:    if (grant) nxt = M_FILL;
            M_FILL:     nxt = zero_word ? M_IDLE : M_STEP;
            M_STEP:     nxt = M_WAIT_ACK;
            M_WAIT_ACK: begin
                if (ack)      nxt = M_NEXT;
                else if (tmo) nxt = M_IDLE;
            end
            M_NEXT: begin
                if (remain != '0)   nxt = M_STEP;
                else if (last_word) nxt = M_IDLE;
                else                nxt = M_FETCH;
            end
            default:    nxt = M_IDLE;
        endcase
    end

    always_comb begin
        req  = (state == M_FETCH);
        step = (state == M_STEP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
            timer  <= '0;
            idx    <= '0;
            dir    <= 1'b0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            unique case (state)
                M_IDLE: if (start) begin
                    idx  <= '0;
                    done <= 1'b0;
                    err  <= 1'b0;
                end
                M_FILL: begin
                    if (zero_word) done <= 1'b1;
                    else begin
                        remain <= mag;
                        dir    <= ~rdata[ENTRY_W-1];
                    end
                end
                M_STEP: timer <= '0;
                M_WAIT_ACK: begin
                    if (ack)      remain <= remain - 1'b1;
                    else if (tmo) err <= 1'b1;
                    else          timer <= timer + 1'b1;
                end
                M_NEXT: if (remain == '0) begin
                    if (last_word) done <= 1'b1;
                    else           idx  <= idx + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step);
    assert_hold_until_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == M_WAIT_ACK && !ack) |=> !step);
    assert_timeout_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == M_WAIT_ACK && !ack && tmo) |=> (err && !done && !step));
    assert_zero_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == M_FILL && zero_word) |=> (done && !req));
    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
    assert_no_timeout_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (limit == '0 && !err) |=> !err);
endmodule

// File: rtl/stepper_table_seq.sv
module stepper_table_seq #(
    parameter int N_MOTORS = 2,
    parameter int ENTRY_W  = 16,
    parameter int DEPTH    = 8,
    parameter int TMO_W    = 12,
    localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int ADDR_W  = $clog2(N_MOTORS * DEPTH),
    localparam int IW      = (N_MOTORS > 1) ? $clog2(N_MOTORS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [TMO_W-1:0]    tmo_limit,
    input  logic [N_MOTORS-1:0] step_ack,
    input  logic [ENTRY_W-1:0]  mem_rdata,
    output logic                mem_rd,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [N_MOTORS-1:0] step_pulse,
    output logic [N_MOTORS-1:0] step_dir,
    output logic [N_MOTORS-1:0] done,
    output logic [N_MOTORS-1:0] fault
);
    logic [N_MOTORS-1:0] req;
    logic [N_MOTORS-1:0] grant;
    logic [IW-1:0]       win;
    logic [IDX_W-1:0]    idx_all [N_MOTORS];

    rr_arbiter #(.N(N_MOTORS)) i_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .grant (grant),
        .win   (win)
    );

    for (genvar m = 0; m < N_MOTORS; m++) begin : g_motor
        motor_seq #(
            .ENTRY_W (ENTRY_W),
            .DEPTH   (DEPTH),
            .TMO_W   (TMO_W)
        ) i_motor (
            .clk   (clk),
            .rst_n (rst_n),
            .start (start),
            .grant (grant[m]),
            .rdata (mem_rdata),
            .ack   (step_ack[m]),
            .limit (tmo_limit),
            .req   (req[m]),
            .idx   (idx_all[m]),
            .step  (step_pulse[m]),
            .dir   (step_dir[m]),
            .done  (done[m]),
            .err   (fault[m])
        );
    end

    always_comb begin
        mem_rd   = |grant;
        mem_addr = ADDR_W'(int'(win) * DEPTH) + ADDR_W'(idx_all[win]);
    end

    assert_read_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (req != '0));
    assert_read_in_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (int'(mem_addr) / DEPTH == int'(win)));
endmodule

// File: tb/test_stepper_table_seq.sv
module test_stepper_table_seq;
    localparam int N = 2;
    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] tmo_limit = 12'd10;
    logic [1:0]  step_ack = '0;
    logic [15:0] mem_rdata = '0;
    logic        mem_rd;
    logic [3:0]  mem_addr;
    logic [1:0]  step_pulse, step_dir, done, fault;

    stepper_table_seq i_stepper_table_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .tmo_limit(tmo_limit),
        .step_ack(step_ack), .mem_rdata(mem_rdata), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .step_pulse(step_pulse), .step_dir(step_dir),
        .done(done), .fault(fault)
    );

    always #2 clk = ~clk;

    logic [15:0] tbl [0:15];
    int checks = 0, errors = 0;
    int dly [N];
    int pos_cnt [N], neg_cnt [N], rd_cnt [N], first_addr [N], viol [N];
    int ord [2];
    int nreads;
    bit pending [N];
    int cnt [N];
    bit prev_step [N];
    bit force_ack = 0;

    always @(posedge clk) if (mem_rd) mem_rdata <= tbl[mem_addr];

    always @(negedge clk) begin
        for (int m = 0; m < N; m++) begin
            step_ack[m] <= force_ack;
            if (pending[m]) begin
                if (cnt[m] == 0) begin step_ack[m] <= 1'b1; pending[m] = 0; end
                else cnt[m]--;
            end
            if (step_pulse[m]) begin
                if (prev_step[m] || pending[m]) viol[m]++;
                if (step_dir[m]) pos_cnt[m]++; else neg_cnt[m]++;
                pending[m] = (dly[m] >= 0);
                cnt[m] = dly[m];
            end
            prev_step[m] = step_pulse[m];
        end
        if (mem_rd) begin
            int mm;
            mm = int'(mem_addr) / D;
            rd_cnt[mm]++;
            if (first_addr[mm] < 0) first_addr[mm] = int'(mem_addr);
            if (nreads < 2) ord[nreads] = int'(mem_addr);
            nreads++;
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic clear_stats();
        for (int m = 0; m < N; m++) begin
            pos_cnt[m] = 0; neg_cnt[m] = 0; rd_cnt[m] = 0;
            first_addr[m] = -1; viol[m] = 0;
        end
        nreads = 0; ord[0] = -1; ord[1] = -1;
    endtask

    task automatic run(input bit restart_mid);
        int guard;
        clear_stats();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        guard = 0;
        while (((done | fault) != 2'b11) && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (restart_mid && guard == 6) start = 1'b1;
            if (restart_mid && guard == 7) start = 1'b0;
        end
        chk(guard < 20000, "R2 run completes", guard, 0);
        repeat (40) @(negedge clk);
    endtask

    task automatic check_motor(input int m);
        int p, n, r;
        logic signed [15:0] e;
        p = 0; n = 0; r = 0;
        for (int i = 0; i < D; i++) begin
            e = tbl[m*D + i];
            r++;
            if (e == 0) break;
            if (e > 0) p += int'(e); else n += -int'(e);
        end
        chk(pos_cnt[m] == p, "R3 forward steps", pos_cnt[m], p);
        chk(neg_cnt[m] == n, "R3 reverse steps", neg_cnt[m], n);
        chk(rd_cnt[m] == r, "R6 R7 words read", rd_cnt[m], r);
        chk(done[m] == 1'b1 && fault[m] == 1'b0, "R6 done flag", {done[m], fault[m]}, 2);
        chk(first_addr[m] == m*D, "R2 first address", first_addr[m], m*D);
        chk(viol[m] == 0, "R4 pulse spacing", viol[m], 0);
    endtask

    task automatic fill(input int m, input int v0, input int v1, input int v2, input int v3);
        for (int i = 0; i < D; i++) tbl[m*D + i] = 16'd0;
        tbl[m*D + 0] = 16'(v0); tbl[m*D + 1] = 16'(v1);
        tbl[m*D + 2] = 16'(v2); tbl[m*D + 3] = 16'(v3);
    endtask

    initial begin
        for (int m = 0; m < N; m++) begin
            dly[m] = 0; pending[m] = 0; cnt[m] = 0; prev_step[m] = 0;
        end
        for (int i = 0; i < 16; i++) tbl[i] = 16'd0;
        clear_stats();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(step_pulse == 2'b00 && done == 2'b00 && fault == 2'b00 && mem_rd == 1'b0,
            "R1 reset outputs", {step_pulse, done, fault, mem_rd}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(step_pulse == 2'b00 && mem_rd == 1'b0, "R1 idle after reset", {step_pulse, mem_rd}, 0);

        // mixed signs, different ack latencies
        fill(0, 3, -2, 1, 0); fill(1, -4, 0, 5, 5);
        dly[0] = 0; dly[1] = 2; tmo_limit = 12'd10;
        run(0);
        check_motor(0); check_motor(1);
        chk(ord[0] == 0 && ord[1] == D, "R10 round-robin order", ord[0]*100 + ord[1], D);

        // R7 full region without zero word
        for (int i = 0; i < D; i++) tbl[i] = 16'd1;
        fill(1, 2, 0, 0, 0);
        dly[0] = 1; dly[1] = 1;
        run(0);
        check_motor(0); check_motor(1);

        // R5 acks while idle are ignored
        clear_stats();
        @(negedge clk) force_ack = 1'b1;
        repeat (3) @(negedge clk);
        force_ack = 1'b0;
        repeat (5) @(negedge clk);
        chk(pos_cnt[0] + neg_cnt[0] + pos_cnt[1] + neg_cnt[1] == 0, "R5 no steps from stray ack",
            pos_cnt[0] + pos_cnt[1], 0);
        chk(done == 2'b11 && nreads == 0, "R5 state unchanged", {done, 1'b0} + nreads, 6);

        // R8 boundary: limit 4, ack at wait cycle 3 accepted, cycle 4 faults
        fill(0, 2, -1, 0, 0); fill(1, 3, 0, 0, 0);
        dly[0] = 3; dly[1] = 4; tmo_limit = 12'd4;
        run(0);
        check_motor(0);
        chk(fault[1] == 1'b1 && done[1] == 1'b0, "R8 fault on late ack", {done[1], fault[1]}, 1);
        chk(pos_cnt[1] == 1 && rd_cnt[1] == 1, "R8 motor stops", pos_cnt[1], 1);

        // R9 limit zero disables timeout
        fill(0, -2, 0, 0, 0); fill(1, 1, 1, 0, 0);
        dly[0] = 30; dly[1] = 25; tmo_limit = 12'd0;
        run(0);
        check_motor(0); check_motor(1);

        // R11 start while busy ignored
        fill(0, 4, -3, 0, 0); fill(1, -5, 0, 0, 0);
        dly[0] = 1; dly[1] = 2; tmo_limit = 12'd8;
        run(1);
        check_motor(0); check_motor(1);

        // sweep of first word and ack latency
        for (int v = -3; v <= 3; v++) begin
            for (int d = 0; d <= 2; d++) begin
                fill(0, v, 2, -1, 0); fill(1, -v, d + 1, 0, 0);
                dly[0] = d; dly[1] = 2 - d; tmo_limit = 12'd3;
                run(0);
                check_motor(0); check_motor(1);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule